// File: doc/BRIEF.md
# Pipeline PC Value Generator

This block owns the program counter of a three-stage fetch, decode and execute pipeline in a 32-bit core whose instructions are all one word long. It issues one fetch address per cycle toward instruction memory. The returned word goes into the decode stage and then into the execute stage. Each instruction carries two addresses with it: the value the program counter reads as when it is used as an operand (instruction address plus 8), and the return address for a call (instruction address plus 4). Both values are captured as the instruction moves through the stages, so a frozen fetch counter cannot corrupt them.

The execute stage can request a taken branch. The branch gives a signed word offset, which is scaled by four and added to the plus-8 value. The execute stage can also request an exception entry to a given vector. Either request flushes decode and execute, and the target executes two cycles later. A multi-cycle instruction in decode raises `stall_decode`. This holds the decode slot and the fetch counter and sends bubbles into execute.

Control is a four-state machine:
- `PS_EMPTY`: both stages invalid. This is the state after reset or a flush.
- `PS_FILL`: decode is valid and execute is empty.
- `PS_FULL`: both stages are valid.
- `PS_HOLD`: decode is held by a stall and execute has a bubble.

Transitions:
- `PS_EMPTY` always moves to `PS_FILL`.
- `PS_FILL` moves to `PS_HOLD` on a stall and to `PS_FULL` otherwise.
- `PS_FULL` moves to `PS_EMPTY` on a redirect, to `PS_HOLD` on a stall, and otherwise stays in `PS_FULL`.
- `PS_HOLD` stays in `PS_HOLD` while the stall lasts and returns to `PS_FULL` when it ends.

Top module: `pipe_pc_gen`

## Requirements
- R1: After reset, `fetch_addr` is 0, `fetch_valid` is 1 and `exec_valid` is 0.
- R2: Without a stall or redirect, `fetch_addr` increases by 4 every cycle. Instructions reach execute in fetch order, and `exec_instr` equals the word that was returned for that address.
- R3: While `exec_valid` is 1, `pc_operand` equals the executing instruction's address plus 8.
- R4: While `exec_valid` is 1 and no interrupt entry is requested, `link_value` equals the executing instruction's address plus 4.
- R5: A taken branch sets the next fetch address to `pc_operand + sign_extend(branch_offset) * 4`. An offset of -2 re-executes the branch itself, and an offset of 0 skips the following instruction.
- R6: After a taken branch or exception entry, `exec_valid` is 0 for exactly two cycles, and then the target instruction executes.
- R7: While `stall_decode` holds a valid decode slot, `fetch_addr` stays constant, `fetch_valid` is 0 and execute receives bubbles. The values carried with the stalled instruction are unchanged when it later executes.
- R8: On exception entry with `exc_kind` = 0 (interrupt), `link_value` in that cycle is the executing address plus 8, so returning to `link_value - 4` resumes at the next instruction. Fetch restarts at `exc_vector`.
- R9: On exception entry with `exc_kind` = 1 (software trap), `link_value` is the trapping address plus 4, and fetch restarts at `exc_vector`.
- R10: When `exc_take` and `branch_take` arrive in the same cycle, the exception wins.
- R11: `branch_take` and `exc_take` have no effect while `exec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | 32 | Address of the word being fetched |
| fetch_valid | output | 1 | The fetched word this cycle will be kept |
| instr_in | input | 32 | Instruction word for `fetch_addr`, same cycle |
| stall_decode | input | 1 | Decode holds a multi-cycle instruction |
| branch_take | input | 1 | Execute-stage instruction takes a branch |
| branch_offset | input | 24 | Signed branch offset in words |
| exc_take | input | 1 | Enter an exception at the execute boundary |
| exc_vector | input | 32 | Exception handler address |
| exc_kind | input | 1 | 0 = interrupt, 1 = software trap |
| exec_valid | output | 1 | Execute stage holds a live instruction |
| exec_instr | output | 32 | Instruction word in execute |
| pc_operand | output | 32 | PC operand value, address plus 8 |
| link_value | output | 32 | Return address for the link register |

## Verification
The hardest case to reach from the ports is a stall that freezes the fetch counter. The stalled instruction's plus-8 value then has to come from the latched copy rather than the live counter. The bench raises `stall_decode` for several cycles right after a known instruction has executed. It checks that the fetch address holds, pulses both redirect requests during the bubbles to show they are ignored, and then compares both carried values when the stalled word finally executes. A second case combines an interrupt and a branch in the same cycle, so that the plus-8 link value and the priority of the exception are both checked on a single instruction.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;

    typedef enum logic [1:0] {
        PS_EMPTY,
        PS_FILL,
        PS_FULL,
        PS_HOLD
    } pipe_state_e;

    localparam logic EXC_INTERRUPT = 1'b0;
    localparam logic EXC_SWTRAP    = 1'b1;

endpackage

// File: rtl/pcgen_ctrl.sv
module pcgen_ctrl
    import pcgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall_req,
    input  logic branch_req,
    input  logic exc_req,
    output logic dec_valid,
    output logic exe_valid,
    output logic hold,
    output logic redirect
);

    pipe_state_e state_q;
    pipe_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_EMPTY: state_d = PS_FILL;
            PS_FILL:  state_d = stall_req ? PS_HOLD : PS_FULL;
            PS_FULL: begin
                if (branch_req || exc_req) state_d = PS_EMPTY;
                else if (stall_req)        state_d = PS_HOLD;
                else                       state_d = PS_FULL;
            end
            PS_HOLD:  state_d = stall_req ? PS_HOLD : PS_FULL;
            default:  state_d = PS_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        dec_valid = (state_q != PS_EMPTY);
        exe_valid = (state_q == PS_FULL);
        redirect  = exe_valid && (branch_req || exc_req);
        hold      = dec_valid && stall_req && !redirect;
    end

endmodule

// File: rtl/pcgen_fetch.sv
module pcgen_fetch #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            redirect,
    input  logic [XLEN-1:0] redirect_addr,
    output logic [XLEN-1:0] fetch_addr,
    output logic [XLEN-1:0] fetch_inc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] fpc_q;

    assign fetch_addr = fpc_q;
    assign fetch_inc  = fpc_q + STEP;

    always_ff @(posedge clk) begin
        if (!rst_n)        fpc_q <= '0;
        else if (redirect) fpc_q <= redirect_addr;
        else if (!hold)    fpc_q <= fetch_inc;
    end

endmodule

// File: rtl/pcgen_latch.sv
module pcgen_latch #(
    parameter int XLEN = 32,
    parameter int IW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            dec_valid,
    input  logic [IW-1:0]   instr_in,
    input  logic [XLEN-1:0] fetch_inc,
    output logic [IW-1:0]   exe_instr,
    output logic [XLEN-1:0] exe_pc4,
    output logic [XLEN-1:0] exe_pc8
);

    logic [IW-1:0]   dec_instr_q;
    logic [XLEN-1:0] dec_pc4_q;

    // plus-4 comes from the fetch incrementer when the word is captured;
    // plus-8 is the same incrementer when the word leaves decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_instr_q <= '0;
            dec_pc4_q   <= '0;
            exe_instr   <= '0;
            exe_pc4     <= '0;
            exe_pc8     <= '0;
        end else if (advance) begin
            dec_instr_q <= instr_in;
            dec_pc4_q   <= fetch_inc;
            if (dec_valid) begin
                exe_instr <= dec_instr_q;
                exe_pc4   <= dec_pc4_q;
                exe_pc8   <= fetch_inc;
            end
        end
    end

endmodule

// File: rtl/pipe_pc_gen.sv
module pipe_pc_gen
    import pcgen_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IW    = 32,
    parameter int OFF_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [XLEN-1:0]  fetch_addr,
    output logic             fetch_valid,
    input  logic [IW-1:0]    instr_in,
    input  logic             stall_decode,
    input  logic             branch_take,
    input  logic [OFF_W-1:0] branch_offset,
    input  logic             exc_take,
    input  logic [XLEN-1:0]  exc_vector,
    input  logic             exc_kind,
    output logic             exec_valid,
    output logic [IW-1:0]    exec_instr,
    output logic [XLEN-1:0]  pc_operand,
    output logic [XLEN-1:0]  link_value
);

    localparam int PAD_W = XLEN - OFF_W - 2;

    logic            dec_valid;
    logic            hold;
    logic            redirect;
    logic [XLEN-1:0] fetch_inc;
    logic [XLEN-1:0] exe_pc4;
    logic [XLEN-1:0] exe_pc8;
    logic [XLEN-1:0] off_bytes;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] redirect_addr;

    pcgen_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_req  (stall_decode),
        .branch_req (branch_take),
        .exc_req    (exc_take),
        .dec_valid  (dec_valid),
        .exe_valid  (exec_valid),
        .hold       (hold),
        .redirect   (redirect)
    );

    pcgen_fetch #(.XLEN(XLEN)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold          (hold),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .fetch_addr    (fetch_addr),
        .fetch_inc     (fetch_inc)
    );

    pcgen_latch #(.XLEN(XLEN), .IW(IW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (!hold && !redirect),
        .dec_valid (dec_valid),
        .instr_in  (instr_in),
        .fetch_inc (fetch_inc),
        .exe_instr (exec_instr),
        .exe_pc4   (exe_pc4),
        .exe_pc8   (exe_pc8)
    );

    assign off_bytes     = {{PAD_W{branch_offset[OFF_W-1]}}, branch_offset, 2'b00};
    assign br_target     = exe_pc8 + off_bytes;
    assign redirect_addr = exc_take ? exc_vector : br_target;
    assign fetch_valid   = !hold && !redirect;
    assign pc_operand    = exe_pc8;
    assign link_value    = (exec_valid && exc_take && (exc_kind == EXC_INTERRUPT))
                           ? exe_pc8 : exe_pc4;

endmodule

// File: rtl/pipe_pc_gen_chk.sv
module pipe_pc_gen_chk #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  fetch_addr,
    input logic             fetch_valid,
    input logic             stall_decode,
    input logic             branch_take,
    input logic [OFF_W-1:0] branch_offset,
    input logic             exc_take,
    input logic [XLEN-1:0]  exc_vector,
    input logic             exc_kind,
    input logic             exec_valid,
    input logic [XLEN-1:0]  pc_operand,
    input logic [XLEN-1:0]  link_value
);

    localparam logic [XLEN-1:0] STEP  = XLEN'(4);
    localparam int              PAD_W = XLEN - OFF_W - 2;

    logic take_any;
    assign take_any = exec_valid && (branch_take || exc_take);

    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> fetch_addr == $past(fetch_addr) + STEP); // R2

    AST_OPERAND_LINK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !(exc_take && exc_kind == 1'b0)) |-> (pc_operand - link_value) == STEP); // R4

    AST_IRQ_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exc_take && exc_kind == 1'b0) |-> link_value == pc_operand); // R8

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && branch_take && !exc_take) |=>
        fetch_addr == $past(pc_operand + {{PAD_W{branch_offset[OFF_W-1]}}, branch_offset, 2'b00})); // R5

    AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exc_take) |=> fetch_addr == $past(exc_vector)); // R10

    AST_REFILL_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> !exec_valid ##1 !exec_valid); // R6

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_decode && !fetch_valid && !take_any) |=> $stable(fetch_addr)); // R7

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_valid && (branch_take || exc_take) && !stall_decode) |=>
        fetch_addr == $past(fetch_addr) + STEP); // R11

endmodule

bind pipe_pc_gen pipe_pc_gen_chk #(.XLEN(XLEN), .OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_addr    (fetch_addr),
    .fetch_valid   (fetch_valid),
    .stall_decode  (stall_decode),
    .branch_take   (branch_take),
    .branch_offset (branch_offset),
    .exc_take      (exc_take),
    .exc_vector    (exc_vector),
    .exc_kind      (exc_kind),
    .exec_valid    (exec_valid),
    .pc_operand    (pc_operand),
    .link_value    (link_value)
);

// File: tb/pipe_pc_gen_tb.sv
module pipe_pc_gen_tb;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] link;
        logic        irq;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr;
    logic        fetch_valid;
    logic [31:0] instr_in;
    logic        stall_decode = 1'b0;
    logic        branch_take = 1'b0;
    logic [23:0] branch_offset = '0;
    logic        exc_take = 1'b0;
    logic [31:0] exc_vector = '0;
    logic        exc_kind = 1'b0;
    logic        exec_valid;
    logic [31:0] exec_instr;
    logic [31:0] pc_operand;
    logic [31:0] link_value;

    int       n_tests = 0;
    int       n_fail  = 0;
    bit       mon_on  = 1'b1;
    bit       done    = 1'b0;
    sb_item_t exp_q[$];

    always #5 clk = ~clk;

    function automatic logic [31:0] enc(input logic [31:0] a);
        return a ^ 32'hC300_0000;
    endfunction

    assign instr_in = enc(fetch_addr);

    pipe_pc_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_addr    (fetch_addr),
        .fetch_valid   (fetch_valid),
        .instr_in      (instr_in),
        .stall_decode  (stall_decode),
        .branch_take   (branch_take),
        .branch_offset (branch_offset),
        .exc_take      (exc_take),
        .exc_vector    (exc_vector),
        .exc_kind      (exc_kind),
        .exec_valid    (exec_valid),
        .exec_instr    (exec_instr),
        .pc_operand    (pc_operand),
        .link_value    (link_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_item(input logic [31:0] a, input logic [31:0] l, input logic irq);
        exp_q.push_back('{addr: a, link: l, irq: irq});
    endtask

    task automatic push_run(input logic [31:0] start, input int n);
        for (int k = 0; k < n; k++)
            push_item(start + 32'(4 * k), start + 32'(4 * k + 4), 1'b0);
    endtask

    task automatic wait_exec(input logic [31:0] a);
        do begin
            @(negedge clk);
            #1;
        end while (!(exec_valid && exec_instr == enc(a)));
    endtask

    task automatic do_branch(input logic [31:0] x, input logic [23:0] off,
                             input logic [31:0] tgt, input int n);
        wait_exec(x);
        push_run(tgt, n);
        branch_take   = 1'b1;
        branch_offset = off;
        @(negedge clk); #1;
        branch_take = 1'b0;
        chk("R5 branch fetch target", fetch_addr, tgt);
        chk("R6 first refill bubble", 32'(exec_valid), 0);
        @(negedge clk); #1;
        chk("R6 second refill bubble", 32'(exec_valid), 0);
    endtask

    task automatic do_exc(input logic [31:0] x, input logic kind, input logic [31:0] vec,
                          input logic with_branch, input int n);
        wait_exec(x);
        push_run(vec, n);
        exc_take      = 1'b1;
        exc_kind      = kind;
        exc_vector    = vec;
        branch_take   = with_branch;
        branch_offset = 24'hFFFFFE;
        @(negedge clk); #1;
        exc_take    = 1'b0;
        branch_take = 1'b0;
        if (kind) chk("R9 trap vector fetch", fetch_addr, vec);
        else      chk("R8 R10 interrupt vector fetch", fetch_addr, vec);
        chk("R6 exception bubble", 32'(exec_valid), 0);
        @(negedge clk); #1;
        chk("R6 exception bubble two", 32'(exec_valid), 0);
    endtask

    // scoreboard monitor: samples after the driver has settled its inputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_on && rst_n && exec_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected execute", exec_instr, 32'hFFFF_FFFF);
                end else begin
                    sb_item_t it;
                    it = exp_q.pop_front();
                    chk("R2 exec order", exec_instr, enc(it.addr));
                    chk("R3 pc operand", pc_operand, it.addr + 32'd8);
                    if (it.irq) chk("R8 interrupt link", link_value, it.link);
                    else        chk("R4 R9 link value", link_value, it.link);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset fetch address", fetch_addr, 32'h0);
        chk("R1 reset exec invalid", 32'(exec_valid), 0);
        chk("R1 reset fetch valid", 32'(fetch_valid), 1);
        push_run(32'h0, 5);

        // R5 offset -2 loops on itself
        do_branch(32'd16, 24'hFFFFFE, 32'd16, 1);
        // R5 offset 0 skips the next word
        do_branch(32'd16, 24'd0, 32'd24, 3);
        // forward and backward offsets
        do_branch(32'd32, 24'd10, 32'd80, 4);
        do_branch(32'd92, 24'hFFFFEC, 32'd20, 4);
        push_item(32'd36, 32'd44, 1'b1);

        // R7 stall after 24 executes; R11 requests during bubbles
        wait_exec(32'd24);
        stall_decode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R7 stall bubble", 32'(exec_valid), 0);
            chk("R7 fetch frozen", fetch_addr, 32'd32);
            chk("R7 fetch not valid", 32'(fetch_valid), 0);
            if (i == 0) begin
                branch_take   = 1'b1;
                branch_offset = 24'd5;
                exc_take      = 1'b1;
                exc_kind      = 1'b1;
                exc_vector    = 32'h300;
            end else begin
                branch_take = 1'b0;
                exc_take    = 1'b0;
            end
        end
        stall_decode = 1'b0;
        @(negedge clk); #1;
        chk("R11 R7 stalled word executes", exec_instr, enc(32'd28));
        chk("R7 operand after stall", pc_operand, 32'd36);

        // R8 interrupt with simultaneous branch (R10)
        do_exc(32'd36, 1'b0, 32'h100, 1'b1, 3);
        // R9 software trap
        do_exc(32'h108, 1'b1, 32'h200, 1'b0, 2);

        wait_exec(32'h204);
        #3;
        mon_on = 1'b0;
        chk("R2 scoreboard drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule